// File: doc/BRIEF.md
# Bounded Range Up-Counter with Wrap Lookahead

This block is a synchronous up-counter that runs over a fixed window of values chosen at build time by two parameters: a lower bound the counter starts from and an upper bound it stops at. The default window is 2 through 9, so the counter visits eight distinct values. One request input advances the count by one. A second request input sends it back to the lower bound. When the counter is advanced while it sits at the upper bound, it returns to the lower bound, not to zero.

Surrounding logic often needs to act in the same cycle as a wrap, so the block also drives three combinational outputs. The first is the value the register will load at the next clock edge. The second flags that a wrap is happening in this cycle. The third flags that a wrap would happen if an advance were requested. The register holds only as many bits as the upper bound needs. A synchronous reset loads the lower bound.

Top module: `range_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count_q` loads START_VAL; after reset is released it reads START_VAL until a request arrives.
- R2: With `step_req` high, `clear_req` low and `count_q` below END_VAL, `count_q` rises by exactly one at the next edge.
- R3: With `step_req` high, `clear_req` low and `count_q` equal to END_VAL, `count_q` becomes START_VAL at the next edge, not zero.
- R4: With `clear_req` high, `count_q` becomes START_VAL at the next edge, whatever `step_req` is; clear wins over step.
- R5: With both requests low, `count_q` keeps its value across the edge.
- R6: `count_nxt` always equals the value that `count_q` takes at the next edge when reset is low.
- R7: `wrap_now` is high exactly when `count_q` equals END_VAL, `step_req` is high and `clear_req` is low.
- R8: `wrap_if_step` is high exactly when `count_q` equals END_VAL, independent of both request inputs.
- R9: Outside reset, `count_q` never leaves the range START_VAL to END_VAL inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; loads START_VAL |
| step_req | input | 1 | Request to advance the count by one |
| clear_req | input | 1 | Request to return the count to START_VAL; overrides step_req |
| count_q | output | W | Registered count; W is the fewest bits that hold END_VAL (4 by default) |
| count_nxt | output | W | Combinational value that count_q loads at the next edge |
| wrap_now | output | 1 | A wrap from END_VAL to START_VAL happens at this edge |
| wrap_if_step | output | 1 | count_q sits at END_VAL, so a step would wrap |

## Verification
A wrong stored count appears on `count_q` and `count_nxt` in the same cycle. A bad successor or priority rule appears one edge later, as a difference between the registered value and the lookahead seen the cycle before. A wrong end-of-range compare shows in two ways. The wrap flags rise at the wrong count, and the count runs past END_VAL or wraps early, which the per-cycle range and value comparison reports within one pass over the window. A reference model advances with every clock, so any divergence is caught in the first cycle it becomes visible at the ports.

// File: rtl/rc_pkg.sv
package rc_pkg;

  // Fewest bits able to hold the value hi (at least one bit).
  function automatic int rc_width(input int hi);
    return (hi < 2) ? 1 : $clog2(hi + 1);
  endfunction

  // Value that follows v in the window lo..hi when a step is taken.
  function automatic int rc_succ(input int v, input int lo, input int hi);
    return (v == hi) ? lo : v + 1;
  endfunction

  // True when v lies inside lo..hi.
  function automatic logic rc_inside(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/rc_next_logic.sv
module rc_next_logic #(
  parameter int START_VAL = 2,
  parameter int END_VAL   = 9,
  parameter int W         = 4
) (
  input  logic [W-1:0] cur,
  input  logic         step_req,
  input  logic         clear_req,
  output logic [W-1:0] nxt,
  output logic         at_end
);
  import rc_pkg::*;

  localparam logic [W-1:0] LO_W = W'(START_VAL);
  localparam logic [W-1:0] HI_W = W'(END_VAL);

  logic [W-1:0] succ;

  assign at_end = (cur == HI_W);
  assign succ   = W'(rc_succ(int'(cur), START_VAL, END_VAL));

  always_comb begin
    if (clear_req)      nxt = LO_W;
    else if (step_req)  nxt = succ;
    else                nxt = cur;
  end

  // R4: a clear request always steers the lookahead to the lower bound
  always_comb begin
    assert_clear_nxt_R4: assert (!(clear_req === 1'b1) || nxt == LO_W);
  end

endmodule

// File: rtl/rc_flag_logic.sv
module rc_flag_logic (
  input  logic at_end,
  input  logic step_req,
  input  logic clear_req,
  output logic wrap_now,
  output logic wrap_if_step
);

  assign wrap_if_step = at_end;
  assign wrap_now     = at_end & step_req & ~clear_req;

endmodule

// File: rtl/range_counter.sv
module range_counter #(
  parameter  int START_VAL = 2,
  parameter  int END_VAL   = 9,
  localparam int W         = rc_pkg::rc_width(END_VAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_req,
  input  logic         clear_req,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_nxt,
  output logic         wrap_now,
  output logic         wrap_if_step
);
  import rc_pkg::*;

  localparam logic [W-1:0] LO_W = W'(START_VAL);
  localparam logic [W-1:0] HI_W = W'(END_VAL);

  logic at_end;

  rc_next_logic #(
    .START_VAL (START_VAL),
    .END_VAL   (END_VAL),
    .W         (W)
  ) u_next (
    .cur       (count_q),
    .step_req  (step_req),
    .clear_req (clear_req),
    .nxt       (count_nxt),
    .at_end    (at_end)
  );

  rc_flag_logic u_flags (
    .at_end       (at_end),
    .step_req     (step_req),
    .clear_req    (clear_req),
    .wrap_now     (wrap_now),
    .wrap_if_step (wrap_if_step)
  );

  always_ff @(posedge clk) begin
    if (rst) count_q <= LO_W;
    else     count_q <= count_nxt;
  end

  // R1: reset loads the lower bound
  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> count_q == LO_W);

  // R2: a step below the end adds one
  assert_step_inc_R2: assert property (@(posedge clk) disable iff (rst)
    (step_req && !clear_req && count_q != HI_W) |=> count_q == $past(count_q) + 1'b1);

  // R3: a wrap lands on the lower bound
  assert_wrap_lo_R3: assert property (@(posedge clk) disable iff (rst)
    wrap_now |=> count_q == LO_W);

  // R4: clear lands on the lower bound
  assert_clear_lo_R4: assert property (@(posedge clk) disable iff (rst)
    clear_req |=> count_q == LO_W);

  // R5: no request, no change
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!step_req && !clear_req) |=> $stable(count_q));

  // R6: lookahead matches what the register takes
  assert_lookahead_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count_q == $past(count_nxt));

  // R7: a wrap only with a step and no clear, and only when a step would wrap
  assert_wrap_cause_R7: assert property (@(posedge clk) disable iff (rst)
    wrap_now |-> (step_req && !clear_req && wrap_if_step));

  // R8: the step-wrap flag predicts a return to the lower bound
  assert_predict_R8: assert property (@(posedge clk) disable iff (rst)
    (wrap_if_step && step_req) |=> count_q == LO_W);

  // R9: the count stays inside the window
  assert_in_window_R9: assert property (@(posedge clk) disable iff (rst)
    rc_inside(int'(count_q), START_VAL, END_VAL));

endmodule

// File: tb/tb_range_counter.sv
`timescale 1ns/100ps
module tb_range_counter;

  localparam int S = 2;
  localparam int E = 9;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_req = 1'b0;
  logic         clear_req = 1'b0;
  logic [W-1:0] count_q;
  logic [W-1:0] count_nxt;
  logic         wrap_now;
  logic         wrap_if_step;

  int checks = 0;
  int fails  = 0;
  int model_v;
  string last_tag;
  bit done = 1'b0;

  range_counter #(.START_VAL(S), .END_VAL(E)) dut (
    .clk (clk), .rst (rst), .step_req (step_req), .clear_req (clear_req),
    .count_q (count_q), .count_nxt (count_nxt),
    .wrap_now (wrap_now), .wrap_if_step (wrap_if_step)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare just after, then let the edge happen.
  task automatic cycle(input bit st, input bit cl);
    int exp_n;
    @(negedge clk);
    step_req  = st;
    clear_req = cl;
    #1;
    exp_n = cl ? S : (st ? ((model_v == E) ? S : model_v + 1) : model_v);
    check(last_tag, int'(count_q), model_v);
    check("R9", int'(count_q >= 4'(S) && count_q <= 4'(E)), 1);
    check("R6", int'(count_nxt), exp_n);
    check("R7", int'(wrap_now), int'(model_v == E && st && !cl));
    check("R8", int'(wrap_if_step), int'(model_v == E));
    if (cl)                    last_tag = "R4";
    else if (st && model_v==E) last_tag = "R3";
    else if (st)               last_tag = "R2";
    else                       last_tag = "R5";
    @(posedge clk);
    model_v = exp_n;
  endtask

  initial begin
    int seed;
    seed = 7;
    model_v = S;
    last_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", int'(count_q), S);
    // full sweep through the window and beyond a wrap
    for (int i = 0; i < 12; i++) cycle(1'b1, 1'b0);
    // idle holding
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0);
    // clear mid range
    cycle(1'b0, 1'b1);
    // climb to the end, then idle while flag is up
    for (int i = 0; i < E - S; i++) cycle(1'b1, 1'b0);
    cycle(1'b0, 1'b0);
    cycle(1'b0, 1'b0);
    // clear and step together at the end: clear wins, no wrap
    cycle(1'b1, 1'b1);
    // clear with step below the end
    cycle(1'b1, 1'b0);
    cycle(1'b1, 1'b1);
    // reset in mid-count
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    step_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step_req = 1'b0;
    model_v = S;
    #1;
    check("R1", int'(count_q), S);
    last_tag = "R1";
    // pseudo-random request mix
    for (int i = 0; i < 300; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      cycle(seed[4] | seed[9], seed[13] & seed[17] & seed[21]);
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule